// File: doc/BRIEF.md
# Multi-Word Transfer Sequencer

This block sits in the control path of a 16-bit processor and turns a single load or store into a burst of adjacent words. A one-cycle prefix instruction arms a block size of 2, 4, 8 or 16 words. The next memory instruction consumes that setting and moves the whole block. Memory instructions that carry no prefix move a single word. The armed size is a one-shot: it never outlives the instruction that follows it, and it is not part of any saved processor state.

For each word the sequencer drives the memory address adder. The first word uses the selected memory pointer plus the instruction's displacement. Every later word feeds the adder's own registered output back with a fixed +2 offset, so each extra word costs one cycle. The sequencer also forces the low bits of the instruction's register field to zero and ORs in the word number, so that each word lands in its own register. The 4-bit register index addresses a general register file (bit 3 = 0) and a memory pointer file (bit 3 = 1). A 16-word load delays its pointer-file writes until the final word, so the pointer file, which holds the program counter, changes all at once.

Progress is paced by a per-cycle step strobe. The base cycle count of the addressing mode (3, 4 or 5) is supplied with each transfer.

Top module: `mwt_sequencer`

## Requirements
- R1: A memory instruction with no armed prefix moves exactly one word, and the burst takes `base_cycles` stepped cycles from the start to the last word.
- R2: A prefix with size code 0, 1, 2 or 3 on `pfx_size` makes the next memory instruction move 2, 4, 8 or 16 words, and the burst takes `base_cycles` + N − 1 stepped cycles.
- R3: The armed size is one-shot. The next memory instruction consumes it. A non-memory instruction that arrives first clears it. A second prefix replaces the pending size.
- R4: The first word's address is `ptr_value + disp` with `base_sel` = 0. Each later word's address is the previous word's address + 2 (modulo 2^16) with `base_sel` = 1.
- R5: Word k uses register index (`reg_field` with its low log2(N) bits cleared) OR k. In 16-word mode, words 0–7 use indices 0–7 (general file, bit 3 = 0) and words 8–15 use indices 8–15 (pointer file, bit 3 = 1).
- R6: In a 16-word load, `ptr_defer` is high on words 8–14 and `ptr_commit` is high only on word 15. Neither is ever high for stores or for any other size.
- R7: `busy` falls and `done` is high in the cycle after the last word. `done` is high for exactly one cycle.
- R8: A cycle with `step` low advances neither the setup count nor the word count.
- R9: Synchronous active-low reset clears `busy`, `done`, `base_sel` and the pending prefix, and aborts any burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfx_valid | input | 1 | Prefix instruction decoded this cycle |
| pfx_size | input | 2 | Prefix size code: 0=2, 1=4, 2=8, 3=16 words |
| mem_start | input | 1 | Memory instruction starts this cycle |
| nonmem_start | input | 1 | Non-memory instruction starts this cycle |
| is_load | input | 1 | 1 = load, 0 = store; sampled at start |
| reg_field | input | 4 | Register address field of the instruction |
| base_cycles | input | 3 | Single-word cycle count of the addressing mode |
| ptr_value | input | 16 | Selected memory pointer value |
| disp | input | 16 | Displacement used for the first word |
| step | input | 1 | Per-cycle advance strobe |
| addr | output | 16 | Address adder result for the current word |
| base_sel | output | 1 | Adder base select: 0 = pointer, 1 = fed-back address |
| reg_idx | output | 4 | Effective register index for the current word |
| word_valid | output | 1 | A word moves this cycle |
| ptr_defer | output | 1 | Pointer-file write of this word is held back |
| ptr_commit | output | 1 | Held pointer-file writes commit now |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last word |

## Verification
The bench runs a single word, all four prefix sizes, loads and stores, and an address that wraps past 0xFFFF. It checks every word's address, register index and deferral flags against values it derives itself. A design that kept the prefix armed would turn a following plain load into a burst. One that let a non-memory instruction or a second prefix leave the old size in place would produce the wrong word count. One that failed to mask the register field would write past the register group, or split a 16-word context switch across the wrong files. Runs with a gapped step strobe and a reset in the middle of a burst check that stalls do not advance the counts, and that a reset leaves neither a half-done burst nor a pending prefix behind.

// File: rtl/mwt_pkg.sv
// Package: shared types and helpers for the multi-word transfer sequencer.
// Assumes the register index is REG_W bits wide, so a burst holds at most 2**REG_W words.
package mwt_pkg;
    localparam int REG_W  = 4;
    localparam int CNT_W  = REG_W + 1;
    localparam int ADDR_W = 16;
    localparam int CYC_W  = 3;

    typedef enum logic [1:0] {
        BLK_2  = 2'd0,
        BLK_4  = 2'd1,
        BLK_8  = 2'd2,
        BLK_16 = 2'd3
    } blk_size_e;

    // Word count of a transfer given the pending prefix state.
    function automatic logic [CNT_W-1:0] words_of(input logic armed, input blk_size_e sz);
        logic [CNT_W-1:0] n;
        n = armed ? (CNT_W'(2) << sz) : CNT_W'(1);
        return n;
    endfunction
endpackage

// File: rtl/mwt_prefix_latch.sv
// Holds the block size armed by a prefix instruction until the next instruction.
// Assumes at most one instruction (prefix, memory or other) starts in a cycle;
// if a prefix coincides with a consume, the new prefix wins.
module mwt_prefix_latch
    import mwt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pfx_valid,
    input  blk_size_e pfx_size,
    input  logic      consume,
    input  logic      cancel,
    output logic      armed,
    output blk_size_e size_q
);
    // Arm on a prefix, disarm on any instruction that follows it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            size_q <= BLK_2;
        end else if (pfx_valid) begin
            armed  <= 1'b1;
            size_q <= pfx_size;
        end else if (consume || cancel) begin
            armed  <= 1'b0;
        end
    end

    // R3: a consumed or cancelled prefix does not survive into the next cycle
    a_r3_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        ((consume || cancel) && !pfx_valid) |=> !armed);
    // R3: a prefix always leaves the latch armed with its own size
    a_r3_replace: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_valid |=> (armed && size_q == $past(pfx_size)));
endmodule

// File: rtl/mwt_addr_path.sv
// Memory address adder with its output register fed back to the base input.
// Assumes base_sel is 0 for the first word and 1 afterwards; the address register
// loads the adder result on every moved word.
module mwt_addr_path #(
    parameter int AW   = 16,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_sel,
    input  logic          word_valid,
    input  logic [AW-1:0] ptr_value,
    input  logic [AW-1:0] disp,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] mar_q;
    logic [AW-1:0] base_in;
    logic [AW-1:0] ofs_in;

    // Select adder operands: pointer plus displacement, or fed-back address plus step.
    always_comb begin
        base_in = base_sel ? mar_q : ptr_value;
        ofs_in  = base_sel ? AW'(STEP) : disp;
        addr    = base_in + ofs_in;
    end

    // Capture the address of each moved word for the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)          mar_q <= '0;
        else if (word_valid) mar_q <= addr;
    end
endmodule

// File: rtl/mwt_burst_ctrl.sv
// Burst controller: counts setup cycles, then words, and derives the register index
// and the deferral flags for the pointer file. Assumes base_cycles >= 1 and that
// start is only honoured while idle (the caller gates it).
module mwt_burst_ctrl
    import mwt_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int CW = CNT_W,
    parameter int SW = CYC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          step,
    input  logic [CW-1:0] n_words,
    input  logic [SW-1:0] base_cycles,
    input  logic [RW-1:0] reg_field,
    input  logic          is_load,
    output logic          busy,
    output logic          done,
    output logic          word_valid,
    output logic          last_word,
    output logic          base_sel,
    output logic [RW-1:0] reg_idx,
    output logic          ptr_defer,
    output logic          ptr_commit
);
    localparam logic [CW-1:0] MAX_WORDS = CW'(1) << RW;

    logic [SW-1:0] setup_left;
    logic [CW-1:0] word_cnt;
    logic [CW-1:0] n_q;
    logic [RW-1:0] reg_base;
    logic          ld_q;
    logic [RW-1:0] low_mask;
    logic          full_load;

    // Mask of register-field bits replaced by the word number.
    assign low_mask = RW'(n_words - CW'(1));

    // Per-word decode: word strobe, last word, register index, deferral flags.
    always_comb begin
        word_valid = busy && step && (setup_left == '0);
        last_word  = (word_cnt == n_q - CW'(1));
        base_sel   = busy && (word_cnt != '0);
        reg_idx    = reg_base | word_cnt[RW-1:0];
        full_load  = ld_q && (n_q == MAX_WORDS);
        ptr_defer  = word_valid && full_load && word_cnt[RW-1] && !last_word;
        ptr_commit = word_valid && full_load && last_word;
    end

    // Sequence state: launch, setup countdown, word count, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            setup_left <= '0;
            word_cnt   <= '0;
            n_q        <= CW'(1);
            reg_base   <= '0;
            ld_q       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy       <= 1'b1;
                setup_left <= base_cycles - SW'(1);
                word_cnt   <= '0;
                n_q        <= n_words;
                reg_base   <= reg_field & ~low_mask;
                ld_q       <= is_load;
            end else if (busy && step) begin
                if (setup_left != '0) begin
                    setup_left <= setup_left - SW'(1);
                end else if (last_word) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    word_cnt <= '0;
                end else begin
                    word_cnt <= word_cnt + CW'(1);
                end
            end
        end
    end

    // R7: the cycle after the last word shows done with busy low
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && last_word) |=> (done && !busy));
    // R7: done never lasts two cycles
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: defer and commit never coincide
    a_r6_defer_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ptr_defer && ptr_commit));
    // R8: a stalled cycle leaves the word count where it was
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step && !start) |=> $stable(word_cnt));
    // R9: reset leaves the sequencer idle
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done));
endmodule

// File: rtl/mwt_sequencer.sv
// Top of the multi-word transfer sequencer: prefix latch, burst controller and
// address path. Assumes the instruction decoder raises at most one of pfx_valid,
// mem_start and nonmem_start per cycle, and that ptr_value and disp stay stable
// until the first word has moved.
module mwt_sequencer
    import mwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfx_valid,
    input  logic [1:0]        pfx_size,
    input  logic              mem_start,
    input  logic              nonmem_start,
    input  logic              is_load,
    input  logic [REG_W-1:0]  reg_field,
    input  logic [CYC_W-1:0]  base_cycles,
    input  logic [ADDR_W-1:0] ptr_value,
    input  logic [ADDR_W-1:0] disp,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              base_sel,
    output logic [REG_W-1:0]  reg_idx,
    output logic              word_valid,
    output logic              ptr_defer,
    output logic              ptr_commit,
    output logic              busy,
    output logic              done
);
    logic             armed;
    blk_size_e        size_q;
    logic             start_ok;
    logic [CNT_W-1:0] n_words;
    logic             last_word;

    // Accept a memory instruction only while idle; size it from the pending prefix.
    assign start_ok = mem_start && !busy;
    assign n_words  = words_of(armed, size_q);

    mwt_prefix_latch u_pfx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pfx_valid (pfx_valid),
        .pfx_size  (blk_size_e'(pfx_size)),
        .consume   (start_ok),
        .cancel    (nonmem_start),
        .armed     (armed),
        .size_q    (size_q)
    );

    mwt_burst_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_ok),
        .step        (step),
        .n_words     (n_words),
        .base_cycles (base_cycles),
        .reg_field   (reg_field),
        .is_load     (is_load),
        .busy        (busy),
        .done        (done),
        .word_valid  (word_valid),
        .last_word   (last_word),
        .base_sel    (base_sel),
        .reg_idx     (reg_idx),
        .ptr_defer   (ptr_defer),
        .ptr_commit  (ptr_commit)
    );

    mwt_addr_path #(.AW(ADDR_W), .STEP(2)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_sel   (base_sel),
        .word_valid (word_valid),
        .ptr_value  (ptr_value),
        .disp       (disp),
        .addr       (addr)
    );

    // R4: after a non-final word the next address is exactly two above it
    a_r4_plus_two: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !last_word) |=> (base_sel && addr == $past(addr) + ADDR_W'(2)));
    // R4: the first word of a burst uses the pointer as base
    a_r4_first_base: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> !base_sel);
endmodule

// File: tb/sim_mwt_sequencer.sv
// Self-checking bench: a vector table of bursts walked by one loop, then directed
// tests for reset, prefix clearing/replacement, stalls and reset mid-burst.
module sim_mwt_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfx_valid = 1'b0;
    logic [1:0]  pfx_size = 2'd0;
    logic        mem_start = 1'b0;
    logic        nonmem_start = 1'b0;
    logic        is_load = 1'b0;
    logic [3:0]  reg_field = 4'd0;
    logic [2:0]  base_cycles = 3'd3;
    logic [15:0] ptr_value = 16'd0;
    logic [15:0] disp = 16'd0;
    logic        step = 1'b0;
    logic [15:0] addr;
    logic        base_sel;
    logic [3:0]  reg_idx;
    logic        word_valid;
    logic        ptr_defer;
    logic        ptr_commit;
    logic        busy;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mwt_sequencer u0 (.*);

    typedef struct packed {
        logic        pfx;
        logic [1:0]  sz;
        logic [2:0]  bc;
        logic [3:0]  rf;
        logic        ld;
        logic [15:0] ptr;
        logic [15:0] dsp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{1'b0, 2'd0, 3'd4, 4'd5,  1'b1, 16'h1000, 16'h0010},
        '{1'b1, 2'd0, 3'd4, 4'd5,  1'b1, 16'h1000, 16'h0010},
        '{1'b1, 2'd1, 3'd3, 4'hB,  1'b0, 16'h2000, 16'h0100},
        '{1'b1, 2'd2, 3'd5, 4'd7,  1'b1, 16'h0400, 16'h0000},
        '{1'b1, 2'd3, 3'd3, 4'hF,  1'b1, 16'h8000, 16'h0020},
        '{1'b1, 2'd3, 3'd4, 4'h6,  1'b0, 16'h8000, 16'h0020},
        '{1'b1, 2'd0, 3'd3, 4'd3,  1'b1, 16'hFFFC, 16'h0000},
        '{1'b0, 2'd0, 3'd5, 4'hE,  1'b0, 16'h0100, 16'hFFFE}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic arm(input logic [1:0] sz);
        pfx_valid = 1'b1;
        pfx_size  = sz;
        @(negedge clk);
        pfx_valid = 1'b0;
    endtask

    // Launch a memory instruction and check every word plus the completion.
    task automatic run_xfer(input int exp_n, input logic [2:0] bc, input logic [3:0] rf,
                            input logic ld, input logic [15:0] ptr, input logic [15:0] dsp,
                            input bit gaps);
        int cyc;
        int k;
        int t;
        logic [3:0] rbase;
        logic [15:0] ea;
        rbase = rf & ~4'(exp_n - 1);
        ptr_value = ptr; disp = dsp; reg_field = rf; is_load = ld; base_cycles = bc;
        mem_start = 1'b1;
        @(negedge clk);
        mem_start = 1'b0;
        cyc = 0; k = 0; t = 0;
        while (busy && t < 200) begin
            step = gaps ? t[0] : 1'b1;
            #1;
            if (step) cyc++;
            if (word_valid) begin
                ea = ptr + dsp + 16'(2 * k);
                chk(addr == ea, "R4 addr", addr, ea);
                chk(base_sel == (k != 0), "R4 base_sel", base_sel, k != 0);
                chk(reg_idx == (rbase | 4'(k)), "R5 reg_idx", reg_idx, rbase | 4'(k));
                chk(ptr_defer == (ld && exp_n == 16 && k >= 8 && k < 15), "R6 defer",
                    ptr_defer, ld && exp_n == 16 && k >= 8 && k < 15);
                chk(ptr_commit == (ld && exp_n == 16 && k == 15), "R6 commit",
                    ptr_commit, ld && exp_n == 16 && k == 15);
                k++;
            end
            @(negedge clk);
            t++;
        end
        step = 1'b0;
        #1;
        chk(k == exp_n, exp_n == 1 ? "R1 word count" : "R2 word count", k, exp_n);
        chk(cyc == bc + exp_n - 1, gaps ? "R8 stepped cycles" : "R2 cycles",
            cyc, bc + exp_n - 1);
        chk(done == 1'b1 && busy == 1'b0, "R7 done high", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !done && !base_sel, "R9 reset state", {busy, done, base_sel}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].pfx) arm(VT[i].sz);
            run_xfer(VT[i].pfx ? (2 << VT[i].sz) : 1, VT[i].bc, VT[i].rf, VT[i].ld,
                     VT[i].ptr, VT[i].dsp, 1'b0);
        end

        // R3: the prefix is consumed; a following plain load is one word
        arm(2'd2);
        run_xfer(8, 3'd3, 4'd0, 1'b1, 16'h0300, 16'h0000, 1'b0);
        run_xfer(1, 3'd3, 4'd9, 1'b1, 16'h0300, 16'h0004, 1'b0);

        // R3: a non-memory instruction clears the pending prefix
        arm(2'd3);
        nonmem_start = 1'b1;
        @(negedge clk);
        nonmem_start = 1'b0;
        run_xfer(1, 3'd4, 4'd2, 1'b1, 16'h0500, 16'h0002, 1'b0);

        // R3: a second prefix replaces the first
        arm(2'd3);
        arm(2'd0);
        run_xfer(2, 3'd3, 4'd13, 1'b0, 16'h0600, 16'h0000, 1'b0);

        // R8: gapped step strobe on a 4-word burst
        arm(2'd1);
        run_xfer(4, 3'd5, 4'd6, 1'b1, 16'h0700, 16'h0008, 1'b1);

        // R9: reset in the middle of a 16-word burst aborts it and drops the prefix
        arm(2'd3);
        mem_start = 1'b1;
        @(negedge clk);
        mem_start = 1'b0;
        step = 1'b1;
        repeat (6) @(negedge clk);
        arm(2'd1);
        step = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!busy && !done && !base_sel, "R9 reset mid-burst", {busy, done, base_sel}, 0);
        @(negedge clk);
        run_xfer(1, 3'd3, 4'd4, 1'b1, 16'h0900, 16'h0000, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule